// File: doc/BRIEF.md
# Page Write Protection Unit

This block sits on the memory write path and screens every write cycle against a per-page protection map. The physical word space (20-bit word address, 1M words) is divided into 1024 pages of 1K words. Two separate one-bit-per-page maps exist: one is consulted when the cycle comes from the CPU, the other when it comes from a DMA master. A write to a page marked as protected in the applicable map is suppressed: the memory write-enable stays low in that same cycle. A sticky error flag is raised, and it records which kind of master caused the violation.

Software loads and reads the maps 16 bits at a time through a small configuration port, which has a map-select bit and a 6-bit word index. The same port clears the error flag. Read cycles pass untouched and never count as violations.

Top module: `wprot_unit`

## Requirements
- R1: On reset every map bit reads back 0, `err_flag` is 0 and `cfg_rdata` is 0.
- R2: A write cycle (`bus_valid`=1, `bus_write`=1) to a page whose bit is 0 in the applicable map drives `mem_we`=1 combinationally in the same cycle.
- R3: `bus_src_cpu`=1 consults the CPU map (`cfg_map`=0). `bus_src_cpu`=0 consults the DMA map (`cfg_map`=1). A bit set in one map has no effect on writes from the other source.
- R4: A write cycle to a protected page drives `mem_we`=0 in that same cycle. `mem_we` is 0 whenever `bus_valid` is 0.
- R5: A violating write sets `err_flag` from the next clock edge on. The flag stays at 1 until it is cleared.
- R6: `err_src_cpu` takes the source of the violation that set the flag (1 = CPU). Later violations while the flag is set do not change it.
- R7: `cfg_clr_err`=1 clears `err_flag` at the next edge. If a violation occurs in the same cycle, the flag stays set and `err_src_cpu` takes that violation's source.
- R8: Read cycles (`bus_write`=0) never drive `mem_we` high and never set `err_flag`.
- R9: The map page number p is stored at word index p[9:4], bit p[3:0]. A write with `cfg_en`=1 and `cfg_wr`=1 stores `cfg_wdata`. A read with `cfg_en`=1 and `cfg_wr`=0 presents the word on `cfg_rdata` after the next edge.
- R10: The page number is `bus_addr[19:10]`. Offset bits [9:0] do not affect the check.
- R11: A map write takes effect at the next edge. A bus write in the same cycle is checked against the old map contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_valid | input | 1 | Bus cycle present |
| bus_write | input | 1 | 1 = write cycle, 0 = read cycle |
| bus_src_cpu | input | 1 | 1 = CPU cycle, 0 = DMA cycle |
| bus_addr | input | 20 | Physical word address |
| mem_we | output | 1 | Write enable passed to memory |
| err_flag | output | 1 | Sticky protection violation flag |
| err_src_cpu | output | 1 | Source of the recorded violation, 1 = CPU |
| cfg_en | input | 1 | Configuration access strobe |
| cfg_wr | input | 1 | 1 = map write, 0 = map read |
| cfg_map | input | 1 | 0 = CPU map, 1 = DMA map |
| cfg_idx | input | 6 | Map word index (page bits [9:4]) |
| cfg_wdata | input | 16 | Map word to store |
| cfg_rdata | output | 16 | Map word read back |
| cfg_clr_err | input | 1 | Clear the error flag |

## Verification
The assertions assume that `bus_write` and `bus_src_cpu` only have meaning while `bus_valid` is high. They also assume that every control input is a clean 0 or 1 on each clock edge. The bench drives all inputs on the falling edge and keeps `bus_valid` low between cycles. It never leaves an input at X after reset, and it issues a clear only as a separate strobe or on a deliberately overlapped cycle. The stickiness and clear-priority properties therefore see only well-formed cycles.

// File: rtl/wprot_pkg.sv
package wprot_pkg;
  typedef enum logic {
    MAP_CPU = 1'b0,
    MAP_DMA = 1'b1
  } map_sel_e;

  localparam int NUM_MAPS = 2;
endpackage

// File: rtl/wprot_map.sv
module wprot_map #(
  parameter int WORDS = 64,
  parameter int DW    = 16,
  localparam int IW   = $clog2(WORDS)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [IW-1:0] wr_idx,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_en,
  input  logic [IW-1:0] rd_idx,
  output logic [DW-1:0] rd_data,
  input  logic [IW-1:0] lk_idx,
  output logic [DW-1:0] lk_data
);
  logic [DW-1:0] mem [WORDS];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < WORDS; i++) mem[i] <= '0;
    end else if (wr_en) begin
      mem[wr_idx] <= wr_data;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else if (rd_en) rd_data <= mem[rd_idx];
  end

  assign lk_data = mem[lk_idx];
endmodule

// File: rtl/wprot_err.sv
module wprot_err (
  input  logic clk,
  input  logic rst,
  input  logic viol,
  input  logic viol_cpu,
  input  logic clr,
  output logic flag,
  output logic src_cpu
);
  always_ff @(posedge clk) begin
    if (rst) begin
      flag    <= 1'b0;
      src_cpu <= 1'b0;
    end else if (viol) begin
      flag <= 1'b1;
      if (!flag || clr) src_cpu <= viol_cpu;
    end else if (clr) begin
      flag <= 1'b0;
    end
  end
endmodule

// File: rtl/wprot_unit.sv
module wprot_unit #(
  parameter int ADDR_W = 20,
  parameter int PAGE_W = 10,
  parameter int DW     = 16
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           bus_valid,
  input  logic                           bus_write,
  input  logic                           bus_src_cpu,
  input  logic [ADDR_W-1:0]              bus_addr,
  output logic                           mem_we,
  output logic                           err_flag,
  output logic                           err_src_cpu,
  input  logic                           cfg_en,
  input  logic                           cfg_wr,
  input  logic                           cfg_map,
  input  logic [PAGE_W-$clog2(DW)-1:0]   cfg_idx,
  input  logic [DW-1:0]                  cfg_wdata,
  output logic [DW-1:0]                  cfg_rdata,
  input  logic                           cfg_clr_err
);
  import wprot_pkg::*;

  localparam int BIT_W = $clog2(DW);
  localparam int IDX_W = PAGE_W - BIT_W;
  localparam int WORDS = 1 << IDX_W;
  localparam int OFS_W = ADDR_W - PAGE_W;

  logic [PAGE_W-1:0] page;
  logic [IDX_W-1:0]  page_idx;
  logic [BIT_W-1:0]  page_bit;
  logic              unused_ofs;

  assign page       = bus_addr[ADDR_W-1 -: PAGE_W];
  assign page_idx   = page[PAGE_W-1 -: IDX_W];
  assign page_bit   = page[BIT_W-1:0];
  assign unused_ofs = ^bus_addr[OFS_W-1:0];

  logic [DW-1:0] rd_word [NUM_MAPS];
  logic [DW-1:0] lk_word [NUM_MAPS];
  logic          rd_sel_q;

  for (genvar g = 0; g < NUM_MAPS; g++) begin : g_map
    logic sel;
    assign sel = (cfg_map == g[0]);
    wprot_map #(.WORDS(WORDS), .DW(DW)) u_map (
      .clk     (clk),
      .rst     (rst),
      .wr_en   (cfg_en && cfg_wr && sel),
      .wr_idx  (cfg_idx),
      .wr_data (cfg_wdata),
      .rd_en   (cfg_en && !cfg_wr && sel),
      .rd_idx  (cfg_idx),
      .rd_data (rd_word[g]),
      .lk_idx  (page_idx),
      .lk_data (lk_word[g])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) rd_sel_q <= 1'b0;
    else if (cfg_en && !cfg_wr) rd_sel_q <= cfg_map;
  end

  assign cfg_rdata = rd_sel_q ? rd_word[MAP_DMA] : rd_word[MAP_CPU];

  logic prot_bit;
  logic is_write;
  logic viol;

  assign prot_bit = bus_src_cpu ? lk_word[MAP_CPU][page_bit] : lk_word[MAP_DMA][page_bit];
  assign is_write = bus_valid && bus_write;
  assign viol     = is_write && prot_bit;
  assign mem_we   = is_write && !prot_bit;

  wprot_err u_err (
    .clk      (clk),
    .rst      (rst),
    .viol     (viol),
    .viol_cpu (bus_src_cpu),
    .clr      (cfg_clr_err),
    .flag     (err_flag),
    .src_cpu  (err_src_cpu)
  );
endmodule

// File: rtl/wprot_chk.sv
module wprot_chk (
  input logic clk,
  input logic rst,
  input logic bus_valid,
  input logic bus_write,
  input logic bus_src_cpu,
  input logic mem_we,
  input logic err_flag,
  input logic err_src_cpu,
  input logic cfg_clr_err
);
  logic bad_wr;
  assign bad_wr = bus_valid && bus_write && !mem_we;

  AST_READ_NO_WE: assert property (@(posedge clk) disable iff (rst)
    (bus_valid && !bus_write) |-> !mem_we); // R8
  AST_IDLE_NO_WE: assert property (@(posedge clk) disable iff (rst)
    !bus_valid |-> !mem_we); // R4
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
    (err_flag && !cfg_clr_err) |=> err_flag); // R5
  AST_FLAG_CAUSE: assert property (@(posedge clk) disable iff (rst)
    $rose(err_flag) |-> $past(bad_wr)); // R5
  AST_SRC_HOLD: assert property (@(posedge clk) disable iff (rst)
    (err_flag && !cfg_clr_err) |=> $stable(err_src_cpu)); // R6
  AST_SRC_CAPTURE: assert property (@(posedge clk) disable iff (rst)
    (bad_wr && (!err_flag || cfg_clr_err)) |=> (err_src_cpu == $past(bus_src_cpu))); // R6
  AST_CLR_WORKS: assert property (@(posedge clk) disable iff (rst)
    (cfg_clr_err && !bad_wr) |=> !err_flag); // R7
  AST_CLR_LOSES: assert property (@(posedge clk) disable iff (rst)
    (cfg_clr_err && bad_wr) |=> err_flag); // R7
endmodule

bind wprot_unit wprot_chk u_chk (
  .clk         (clk),
  .rst         (rst),
  .bus_valid   (bus_valid),
  .bus_write   (bus_write),
  .bus_src_cpu (bus_src_cpu),
  .mem_we      (mem_we),
  .err_flag    (err_flag),
  .err_src_cpu (err_src_cpu),
  .cfg_clr_err (cfg_clr_err)
);

// File: tb/tb_wprot_unit.sv
module tb_wprot_unit;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_valid = 1'b0, bus_write = 1'b0, bus_src_cpu = 1'b0;
  logic [19:0] bus_addr = '0;
  logic        mem_we, err_flag, err_src_cpu;
  logic        cfg_en = 1'b0, cfg_wr = 1'b0, cfg_map = 1'b0, cfg_clr_err = 1'b0;
  logic [5:0]  cfg_idx = '0;
  logic [15:0] cfg_wdata = '0;
  logic [15:0] cfg_rdata;

  int errors = 0;
  int checks = 0;

  always #2.5 clk = ~clk;

  wprot_unit dut (.*);

  // {write, cpu, addr, expected mem_we}
  localparam logic [22:0] VEC [12] = '{
    {1'b1, 1'b1, 20'h00000, 1'b0},
    {1'b1, 1'b0, 20'h00000, 1'b1},
    {1'b1, 1'b1, 20'h003FF, 1'b0},
    {1'b1, 1'b1, 20'h00400, 1'b1},
    {1'b1, 1'b1, 20'hFFC00, 1'b0},
    {1'b1, 1'b0, 20'hFFFFF, 1'b1},
    {1'b1, 1'b0, 20'h04800, 1'b0},
    {1'b1, 1'b1, 20'h04800, 1'b1},
    {1'b0, 1'b1, 20'h00000, 1'b0},
    {1'b1, 1'b0, 20'h01400, 1'b0},
    {1'b1, 1'b1, 20'h017FF, 1'b0},
    {1'b1, 1'b1, 20'h04BFF, 1'b1}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cfg_write(input logic map, input logic [5:0] idx, input logic [15:0] d);
    @(negedge clk);
    cfg_en = 1'b1; cfg_wr = 1'b1; cfg_map = map; cfg_idx = idx; cfg_wdata = d;
    @(negedge clk);
    cfg_en = 1'b0; cfg_wr = 1'b0;
  endtask

  task automatic cfg_read(input logic map, input logic [5:0] idx, output logic [15:0] d);
    @(negedge clk);
    cfg_en = 1'b1; cfg_wr = 1'b0; cfg_map = map; cfg_idx = idx;
    @(negedge clk);
    cfg_en = 1'b0;
    d = cfg_rdata;
  endtask

  task automatic bus(input logic w, input logic cpu, input logic [19:0] a,
                     input logic clr, output logic we_seen);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = w; bus_src_cpu = cpu; bus_addr = a; cfg_clr_err = clr;
    #1 we_seen = mem_we;
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0; cfg_clr_err = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [15:0] rd;
    logic        we;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    chk("R1 err_flag after reset", err_flag, 1'b0);
    chk("R1 cfg_rdata after reset", cfg_rdata, 16'h0);
    cfg_read(1'b0, 6'd0, rd);  chk("R1 cpu map word0", rd, 16'h0);
    cfg_read(1'b1, 6'd63, rd); chk("R1 dma map word63", rd, 16'h0);

    // R9 readback and map independence
    cfg_write(1'b0, 6'd10, 16'hA5C3);
    cfg_read(1'b0, 6'd10, rd); chk("R9 cpu readback", rd, 16'hA5C3);
    cfg_read(1'b1, 6'd10, rd); chk("R9 dma word untouched", rd, 16'h0);
    cfg_write(1'b0, 6'd10, 16'h0000);

    // map setup: CPU pages 0,5,1023; DMA pages 5,18
    cfg_write(1'b0, 6'd0,  16'h0021);
    cfg_write(1'b0, 6'd63, 16'h8000);
    cfg_write(1'b1, 6'd0,  16'h0020);
    cfg_write(1'b1, 6'd1,  16'h0004);

    // R2 R3 R4 R7 R8 R10: each vector overlaps a clear, so the flag reflects that vector only
    foreach (VEC[i]) begin
      logic v_w, v_cpu, v_exp, v_viol;
      v_w = VEC[i][22]; v_cpu = VEC[i][21]; v_exp = VEC[i][0];
      v_viol = v_w && !v_exp;
      bus(v_w, v_cpu, VEC[i][20:1], 1'b1, we);
      chk($sformatf("R2/R3/R4/R10 mem_we vec%0d", i), we, v_exp);
      chk($sformatf("R5/R7/R8 err_flag vec%0d", i), err_flag, v_viol);
      if (v_viol) chk($sformatf("R6 err_src vec%0d", i), err_src_cpu, v_cpu);
    end

    // R5 sticky, R6 first source retained
    bus(1'b1, 1'b1, 20'h00000, 1'b0, we);
    chk("R4 cpu protected write", we, 1'b0);
    repeat (2) @(negedge clk);
    chk("R5 flag sticky", err_flag, 1'b1);
    chk("R6 src cpu", err_src_cpu, 1'b1);
    bus(1'b1, 1'b0, 20'h04800, 1'b0, we);
    chk("R6 src kept after dma violation", err_src_cpu, 1'b1);
    @(negedge clk); cfg_clr_err = 1'b1;
    @(negedge clk); cfg_clr_err = 1'b0;
    chk("R7 clear", err_flag, 1'b0);
    bus(1'b0, 1'b0, 20'h04800, 1'b0, we);
    chk("R8 read no flag", err_flag, 1'b0);
    bus(1'b1, 1'b0, 20'h04800, 1'b0, we);
    chk("R6 src dma", err_src_cpu, 1'b0);
    chk("R5 flag set", err_flag, 1'b1);

    // R11: map write and bus write in the same cycle (page 32)
    @(negedge clk);
    cfg_en = 1'b1; cfg_wr = 1'b1; cfg_map = 1'b0; cfg_idx = 6'd2; cfg_wdata = 16'h0001;
    bus_valid = 1'b1; bus_write = 1'b1; bus_src_cpu = 1'b1; bus_addr = 20'h08000;
    #1 chk("R11 old map used", mem_we, 1'b1);
    @(negedge clk);
    cfg_en = 1'b0; cfg_wr = 1'b0;
    #1 chk("R11 new map next cycle", mem_we, 1'b0);
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0;

    // R1 reset mid-run clears maps and flag
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    chk("R1 flag cleared by reset", err_flag, 1'b0);
    cfg_read(1'b0, 6'd0, rd); chk("R1 cpu map cleared", rd, 16'h0);
    bus(1'b1, 1'b1, 20'h00000, 1'b0, we);
    chk("R1 page0 writable after reset", we, 1'b1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule